// File: doc/BRIEF.md
# Link Destination Output Stage with Error Reporting

This block sits at the receiving end of a serial data link, after the deserializer. It takes decoded 32-bit words from a valid/ready stream. Each word carries a tag that marks it as a control word and a flag that marks it as corrupted in transit. The block registers every accepted word and presents it to a readout user on the link clock (`clk`), using an active-low write strobe and an active-low control flag. An active-low error flag reports transmission errors under one of two policies:

- **Per word:** the flag goes low on each bad word and again on the control word that closes the block.
- **Per block:** the flag goes low only on the closing control word of a block that held a bad word.

Test mode is entered through an asynchronous active-low input. In this mode the block checks incoming words against a locally regenerated incrementing counter and reports mismatches on the error flag. It forwards the pattern to the user only if a forwarding input, captured at configuration time, asked for it.

The block also passes the user's transmit-off request toward the sender. While test mode runs without forwarding, that request is suppressed. The block drives a link-down indication, which is low in three cases: during reset and configuration, in test mode, and after a link failure. A failure latches until the next reset.

The input stream applies back-pressure only through `in_ready`. `in_ready` is low during reset, during the configuration cycle and after a latched failure. Otherwise it is high, and every word offered is taken on that edge. The user side has no back-pressure, because each accepted word gives exactly one strobe cycle.

Top module: `lnk_dest_out`

## Requirements
- R1: A word accepted on a rising edge (`in_valid` and `in_ready` high) appears on `out_data` with `out_wen_n` low during the following cycle. Each accepted word gives exactly one strobe cycle, and `out_wen_n` is high in every other cycle.
- R2: A word with `in_ctrl` high is presented with `out_ctrl_n` low, and all 32 data bits are unchanged, including the special field in bits 3..0. A data word is presented with `out_ctrl_n` high.
- R3: With the per-word policy (`cfg_block_mode` = 0 at capture), `out_derr_n` is low together with each data word whose `in_err` is high. It is also low with the control word that closes a block containing such a word.
- R4: With the per-block policy (`cfg_block_mode` = 1 at capture), `out_derr_n` is never low with a data word. It is low with a closing control word if any data word of that block, or the control word itself, had `in_err` high.
- R5: The per-block error record is cleared once its closing control word is output. In the next block, a clean block gives `out_derr_n` high on its control word.
- R6: `cfg_block_mode` and `cfg_tdo_n` are captured on the first rising edge after reset release. `in_ready` is low until that edge. Later changes to these inputs have no effect until the next reset.
- R7: While `test_n` is low (after a 2-stage synchronizer), the following hold:
  - `link_down_n` is low.
  - Each accepted word is compared with an expected value that starts at 0 on entry to test mode and becomes the received word + 1 after each word.
  - A mismatch drives `out_derr_n` low in that word's output cycle.
  - `in_ctrl` and `in_err` are ignored.
- R8: In test mode, pattern words are forwarded with `out_wen_n` low and `out_ctrl_n` high only if `cfg_tdo_n` was captured low. If it was captured high, `out_wen_n` stays high.
- R9: `send_xoff_n` follows `user_xoff_n`, except in test mode with `cfg_tdo_n` captured high, when it is held high.
- R10: A high `link_fail` at a rising edge latches a failure. From the next cycle `link_down_n` and `in_ready` stay low until reset.
- R11: During reset, `link_down_n` is low and `out_wen_n`, `out_ctrl_n` and `out_derr_n` are high. After the configuration edge, `link_down_n` is high when there is neither test mode nor a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; all user-side outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded word offered |
| in_ready | output | 1 | Block takes the word on this edge |
| in_data | input | 32 | Decoded word |
| in_ctrl | input | 1 | Word is a control word (closes a block) |
| in_err | input | 1 | Word was corrupted in transit |
| link_fail | input | 1 | Link failure pulse from the deserializer |
| cfg_block_mode | input | 1 | 0 = per-word error policy, 1 = per-block; captured after reset |
| cfg_tdo_n | input | 1 | Active low: forward the test pattern to the user; captured after reset |
| test_n | input | 1 | Asynchronous active-low test-mode request |
| user_xoff_n | input | 1 | Asynchronous active-low transmit-off request from the user |
| out_data | output | 32 | Word presented to the user |
| out_wen_n | output | 1 | Active-low write strobe |
| out_ctrl_n | output | 1 | Active-low control-word flag |
| out_derr_n | output | 1 | Active-low error flag |
| send_xoff_n | output | 1 | Active-low transmit-off toward the sender |
| link_down_n | output | 1 | Active-low link-not-operational indication |

## Verification
The assertions check on every cycle that:
- no strobe appears without a word accepted on the previous edge;
- the control flag never appears without the strobe;
- the per-block policy never flags a data word;
- a latched failure holds both `in_ready` and `link_down_n` low;
- test mode holds `link_down_n` low;
- a transmit-off request passes through while the link is up.

Some behaviours need the bench's scenarios to show them:
- the exact error pattern across sequences of blocks;
- the clearing of the block record;
- the counter comparison and its resynchronization after a mismatch;
- whether test words are forwarded;
- the configuration values being ignored after capture.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic {
    RPT_WORD  = 1'b0,
    RPT_BLOCK = 1'b1
  } rpt_mode_e;

  localparam int unsigned LNK_DATA_W = 32;
endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= {STAGES{RST_VAL}};
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lnk_cfg.sv
module lnk_cfg
  import lnk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_block_mode,
  input  logic      cfg_tdo_n,
  input  logic      link_fail,
  input  logic      test_act,
  output logic      cfg_done,
  output rpt_mode_e mode,
  output logic      fwd_test,
  output logic      fail_q,
  output logic      ready,
  output logic      link_down_n
);
  // Static inputs are taken once, on the first edge after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      mode     <= RPT_WORD;
      fwd_test <= 1'b0;
    end else if (!cfg_done) begin
      cfg_done <= 1'b1;
      mode     <= cfg_block_mode ? RPT_BLOCK : RPT_WORD;
      fwd_test <= ~cfg_tdo_n;
    end
  end

  // A failure is sticky until the next reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fail_q <= 1'b0;
    else if (link_fail) fail_q <= 1'b1;
  end

  assign ready       = cfg_done & ~fail_q;
  assign link_down_n = cfg_done & ~fail_q & ~test_act;
endmodule

// File: rtl/lnk_pattern.sv
module lnk_pattern #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_act,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  output logic              mismatch
);
  logic [DATA_W-1:0] expect_q;

  assign mismatch = (data != expect_q);

  // Expected value restarts at zero outside test mode and resynchronizes
  // to the received word after each word, so one bad word flags once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             expect_q <= '0;
    else if (!test_act)     expect_q <= '0;
    else if (accept)        expect_q <= data + 1'b1;
  end
endmodule

// File: rtl/lnk_err_policy.sv
module lnk_err_policy
  import lnk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  logic      test_act,
  input  logic      is_ctrl,
  input  logic      is_err,
  input  rpt_mode_e mode,
  output logic      flag
);
  logic blk_err_q;

  always_comb begin
    if (is_ctrl) flag = blk_err_q | is_err;
    else         flag = (mode == RPT_WORD) & is_err;
  end

  // Per-block error record; held while test mode runs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_err_q <= 1'b0;
    else if (accept && !test_act) begin
      if (is_ctrl) blk_err_q <= 1'b0;
      else         blk_err_q <= blk_err_q | is_err;
    end
  end
endmodule

// File: rtl/lnk_dest_out.sv
module lnk_dest_out
  import lnk_pkg::*;
#(
  parameter int unsigned DATA_W      = LNK_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ctrl,
  input  logic              in_err,
  input  logic              link_fail,
  input  logic              cfg_block_mode,
  input  logic              cfg_tdo_n,
  input  logic              test_n,
  input  logic              user_xoff_n,
  output logic [DATA_W-1:0] out_data,
  output logic              out_wen_n,
  output logic              out_ctrl_n,
  output logic              out_derr_n,
  output logic              send_xoff_n,
  output logic              link_down_n
);
  logic      test_sync_n;
  logic      test_act;
  logic      cfg_done;
  rpt_mode_e mode;
  logic      fwd_test;
  logic      fail_q;
  logic      accept;
  logic      mismatch;
  logic      err_flag;

  lnk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_test_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (test_n),
    .q     (test_sync_n)
  );
  assign test_act = ~test_sync_n;

  lnk_cfg u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_block_mode (cfg_block_mode),
    .cfg_tdo_n      (cfg_tdo_n),
    .link_fail      (link_fail),
    .test_act       (test_act),
    .cfg_done       (cfg_done),
    .mode           (mode),
    .fwd_test       (fwd_test),
    .fail_q         (fail_q),
    .ready          (in_ready),
    .link_down_n    (link_down_n)
  );

  assign accept = in_valid & in_ready;

  lnk_pattern #(.DATA_W(DATA_W)) u_pattern (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_act (test_act),
    .accept   (accept),
    .data     (in_data),
    .mismatch (mismatch)
  );

  lnk_err_policy u_policy (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .test_act (test_act),
    .is_ctrl  (in_ctrl),
    .is_err   (in_err),
    .mode     (mode),
    .flag     (err_flag)
  );

  // Transmit-off passes through, except that a non-forwarded test pattern
  // keeps flowing.
  assign send_xoff_n = (test_act & ~fwd_test) ? 1'b1 : user_xoff_n;

  // User-side output register: one strobe cycle per accepted word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data   <= '0;
      out_wen_n  <= 1'b1;
      out_ctrl_n <= 1'b1;
      out_derr_n <= 1'b1;
    end else begin
      out_wen_n  <= 1'b1;
      out_ctrl_n <= 1'b1;
      out_derr_n <= 1'b1;
      if (accept) begin
        if (test_act) begin
          out_derr_n <= ~mismatch;
          if (fwd_test) begin
            out_wen_n <= 1'b0;
            out_data  <= in_data;
          end
        end else begin
          out_wen_n  <= 1'b0;
          out_ctrl_n <= ~in_ctrl;
          out_derr_n <= ~err_flag;
          out_data   <= in_data;
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = cfg_done;
endmodule

// File: rtl/lnk_dest_out_chk.sv
module lnk_dest_out_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic link_fail,
  input logic user_xoff_n,
  input logic out_wen_n,
  input logic out_ctrl_n,
  input logic out_derr_n,
  input logic send_xoff_n,
  input logic link_down_n,
  input logic test_act,
  input logic blk_mode
);
  logic fail_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fail_seen <= 1'b0;
    else if (link_fail) fail_seen <= 1'b1;
  end

  // R1
  strobe_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> out_wen_n);

  // R2
  ctrl_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ctrl_n |-> !out_wen_n);

  // R4
  block_no_data_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_mode && !test_act && !$past(test_act) && !out_wen_n && out_ctrl_n)
      |-> out_derr_n);

  // R7
  test_link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_act |-> !link_down_n);

  // R9
  xoff_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_down_n && !user_xoff_n) |-> !send_xoff_n);

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_seen |-> (!in_ready && !link_down_n));
endmodule

bind lnk_dest_out lnk_dest_out_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .link_fail   (link_fail),
  .user_xoff_n (user_xoff_n),
  .out_wen_n   (out_wen_n),
  .out_ctrl_n  (out_ctrl_n),
  .out_derr_n  (out_derr_n),
  .send_xoff_n (send_xoff_n),
  .link_down_n (link_down_n),
  .test_act    (test_act),
  .blk_mode    (mode == lnk_pkg::RPT_BLOCK)
);

// File: tb/lnk_dest_out_bench.sv
module lnk_dest_out_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_ctrl = 1'b0;
  logic        in_err = 1'b0;
  logic        link_fail = 1'b0;
  logic        cfg_block_mode = 1'b0;
  logic        cfg_tdo_n = 1'b0;
  logic        test_n = 1'b1;
  logic        user_xoff_n = 1'b1;
  logic [31:0] out_data;
  logic        out_wen_n, out_ctrl_n, out_derr_n, send_xoff_n, link_down_n;

  int tests = 0;
  int fails = 0;
  int err_pulses = 0;
  bit done = 1'b0;

  logic [33:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  lnk_dest_out u_lnk_dest_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_ctrl(in_ctrl), .in_err(in_err),
    .link_fail(link_fail), .cfg_block_mode(cfg_block_mode),
    .cfg_tdo_n(cfg_tdo_n), .test_n(test_n), .user_xoff_n(user_xoff_n),
    .out_data(out_data), .out_wen_n(out_wen_n), .out_ctrl_n(out_ctrl_n),
    .out_derr_n(out_derr_n), .send_xoff_n(send_xoff_n),
    .link_down_n(link_down_n)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected item per strobe cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_wen_n === 1'b0) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected strobe", 64'd1, 64'd0);
        end else begin
          logic [33:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(r, {30'd0, out_ctrl_n, out_derr_n, out_data}, {30'd0, e});
        end
      end else if (out_derr_n === 1'b0) begin
        err_pulses++;
      end
    end
  end

  // Called at a negedge; leaves the word valid across one rising edge.
  task automatic send(input logic [31:0] d, input logic c, input logic e,
                      input logic fwd, input logic exp_ctrl_n,
                      input logic exp_derr_n, input string req);
    in_valid = 1'b1; in_data = d; in_ctrl = c; in_err = e;
    if (fwd) begin
      exp_q.push_back({exp_ctrl_n, exp_derr_n, d});
      req_q.push_back(req);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_ctrl = 1'b0; in_err = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic blk, input logic tdo_n);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; test_n = 1'b1; link_fail = 1'b0;
    user_xoff_n = 1'b1; cfg_block_mode = blk; cfg_tdo_n = tdo_n;
    repeat (2) @(negedge clk);
    check("R11 reset strobe", {63'd0, out_wen_n}, 64'd1);
    check("R11 reset ctrl/derr", {62'd0, out_ctrl_n, out_derr_n}, 64'd3);
    check("R11 reset link down", {63'd0, link_down_n}, 64'd0);
    rst_n = 1'b1;
    #1;
    check("R6 ready low before capture", {63'd0, in_ready}, 64'd0);
    check("R11 down before capture", {63'd0, link_down_n}, 64'd0);
    @(negedge clk);
    check("R6 ready after capture", {63'd0, in_ready}, 64'd1);
    check("R11 up after capture", {63'd0, link_down_n}, 64'd1);
  endtask

  initial begin
    // Per-word policy, forwarding enabled.
    do_reset(1'b0, 1'b0);
    send(32'h1111_0000, 0, 0, 1, 1, 1, "R1 clean data");
    send(32'h2222_0001, 0, 1, 1, 1, 0, "R3 bad data word");
    send(32'hC0DE_000A, 1, 0, 1, 0, 0, "R3 closing ctrl of bad block");
    send(32'h3333_0002, 0, 0, 1, 1, 1, "R5 clean data next block");
    send(32'hC0DE_0005, 1, 0, 1, 0, 1, "R5 R2 clean ctrl bits 3..0");
    // Configuration change after capture is ignored.
    cfg_block_mode = 1'b1;
    send(32'h4444_0003, 0, 1, 1, 1, 0, "R6 mode change ignored");
    send(32'hC0DE_000F, 1, 0, 1, 0, 0, "R6 ctrl after ignored change");
    idle(2);
    check("R1 idle no strobe", {63'd0, out_wen_n}, 64'd1);
    user_xoff_n = 1'b0; #1;
    check("R9 xoff passes", {63'd0, send_xoff_n}, 64'd0);
    user_xoff_n = 1'b1; #1;
    check("R9 xoff released", {63'd0, send_xoff_n}, 64'd1);

    // Per-block policy.
    do_reset(1'b1, 1'b0);
    send(32'h5555_0000, 0, 1, 1, 1, 1, "R4 bad data not flagged");
    send(32'h5555_0001, 0, 0, 1, 1, 1, "R4 clean data");
    send(32'hC0DE_0003, 1, 0, 1, 0, 0, "R4 ctrl closes bad block");
    send(32'h6666_0000, 0, 0, 1, 1, 1, "R4 clean data");
    send(32'hC0DE_0006, 1, 1, 1, 0, 0, "R4 ctrl itself bad");
    send(32'h7777_0000, 0, 0, 1, 1, 1, "R5 clean data");
    send(32'hC0DE_0009, 1, 0, 1, 0, 1, "R5 record cleared");
    idle(2);

    // Test mode with forwarding.
    test_n = 1'b0;
    idle(3);
    check("R7 test mode link down", {63'd0, link_down_n}, 64'd0);
    send(32'd0, 1, 1, 1, 1, 1, "R8 R7 pattern 0 fwd, ctrl/err ignored");
    send(32'd1, 0, 0, 1, 1, 1, "R8 pattern 1");
    send(32'd2, 0, 0, 1, 1, 1, "R8 pattern 2");
    send(32'd7, 0, 0, 1, 1, 0, "R7 mismatch flagged");
    send(32'd8, 0, 0, 1, 1, 1, "R7 resync after mismatch");
    user_xoff_n = 1'b0; #1;
    check("R9 xoff in forwarding test", {63'd0, send_xoff_n}, 64'd0);
    user_xoff_n = 1'b1;
    idle(1);
    test_n = 1'b1;
    idle(3);
    check("R11 up after test exit", {63'd0, link_down_n}, 64'd1);

    // Test mode without forwarding.
    do_reset(1'b0, 1'b1);
    test_n = 1'b0;
    idle(3);
    err_pulses = 0;
    send(32'd0, 0, 0, 0, 1, 1, "R8");
    send(32'd1, 0, 0, 0, 1, 1, "R8");
    send(32'd5, 0, 0, 0, 1, 1, "R8");
    send(32'd6, 0, 0, 0, 1, 1, "R8");
    idle(2);
    check("R7 R8 one mismatch pulse, no strobe", err_pulses, 64'd1);
    user_xoff_n = 1'b0; #1;
    check("R9 xoff held in test without fwd", {63'd0, send_xoff_n}, 64'd1);
    user_xoff_n = 1'b1;
    test_n = 1'b1;
    idle(3);

    // Latched failure.
    link_fail = 1'b1;
    @(negedge clk);
    link_fail = 1'b0;
    check("R10 ready low after fail", {63'd0, in_ready}, 64'd0);
    check("R10 link down after fail", {63'd0, link_down_n}, 64'd0);
    idle(5);
    check("R10 fail still latched", {62'd0, in_ready, link_down_n}, 64'd0);
    do_reset(1'b0, 1'b0);
    check("R10 reset clears fail", {63'd0, link_down_n}, 64'd1);

    idle(2);
    check("R1 every expected word seen", exp_q.size(), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule